// File: doc/BRIEF.md
# Word-Wise Serial Loopback Transfer Engine

This block carries a message payload through a single serial shift register while the controller runs in loopback. When a transfer is started, it reads the payload from the transmit half of a transient buffer one 32-bit word at a time. Each word goes into the shift register and is sent out serially, most significant bit first, with one bit per bit-clock strobe. The bit leaving the top of the register is fed straight back into its bottom. Once every bit has gone round, the register holds the looped-back word. That word is written into the receive half of the buffer before the next transmit word is fetched.

The payload length is given in 16-bit halfwords. When the length is odd, only the upper halfword of the final transmit word is sent, which takes 16 strobes. The captured halfword lands right-aligned in the final receive word, and the upper half of that word is zero. A channel-select input picks which channel's buffer pair is used, and the choice holds for the whole transfer. A one-cycle done pulse closes each transfer.

Top module: `lpbk_word_engine`

## Requirements
- R1: After reset the block is idle: busy_o=0, done_o=0, tx_rd_en_o=0, rx_wr_en_o=0, ser_en_o=0 and ser_o=1.
- R2: A transfer of L halfwords reads ceil(L/2) words from the transmit buffer, at word addresses 0, 1, 2 and onward in increasing order. Read data is expected on tx_rd_data_i one cycle after tx_rd_en_o.
- R3: While ser_en_o is high, ser_o presents the shift register's MSB. On each cycle with bit_en_i high the register rotates left by one. A cycle with bit_en_i low leaves it unchanged. Each full word therefore goes out as bits 31 down to 0.
- R4: Each captured word is written to the receive buffer at the address it was read from. For a full word the data equals the word that was read. The write happens before the next transmit read.
- R5: For an odd L, the final word is shifted for only 16 strobes, which send bits 31..16. It is written as {16'h0000, read_word[31:16]}.
- R6: chan_i is captured at start and presented on tx_rd_ch_o and rx_wr_ch_o for the whole transfer.
- R7: done_o is high for exactly one cycle, in the cycle after the final receive write. busy_o drops in the following cycle.
- R8: A start_i pulse while busy_o is high is ignored. It changes neither the length nor the channel of the running transfer.
- R9: A start with L=0 produces one done_o pulse with no reads and no writes.
- R10: ser_o is high whenever ser_en_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| len_hw_i | input | LEN_W | Payload length in 16-bit halfwords |
| chan_i | input | CH_W | Channel select |
| bit_en_i | input | 1 | Bit-clock strobe, one shift per high cycle |
| tx_rd_en_o | output | 1 | Transmit buffer read request |
| tx_rd_ch_o | output | CH_W | Transmit buffer channel |
| tx_rd_addr_o | output | LEN_W-1 | Transmit buffer word address |
| tx_rd_data_i | input | WORD_W | Transmit buffer read data, one cycle after the request |
| rx_wr_en_o | output | 1 | Receive buffer write strobe |
| rx_wr_ch_o | output | CH_W | Receive buffer channel |
| rx_wr_addr_o | output | LEN_W-1 | Receive buffer word address |
| rx_wr_data_o | output | WORD_W | Receive buffer write data |
| ser_o | output | 1 | Serial bit stream, high when idle |
| ser_en_o | output | 1 | High while the shift register is shifting |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle end-of-transfer pulse |

## Verification
Transfers are run with even lengths, odd lengths, a single halfword, zero and the 127-halfword maximum. A word-count or alignment slip shows only on one side of the even/odd split, and an off-by-one in the last address shows only at the extremes. Each length is run with a strobe on every cycle and with a strobe on every third cycle. A shift that ignores the strobe passes the first pattern and corrupts the serial stream under the second. Both channels are used with different buffer contents, which exposes a swapped or unlatched channel. A start pulse injected in the middle of a transfer separates a correctly ignored request from one that restarts or retargets the engine.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_SHIFT,
    ST_WRITE,
    ST_DONE
  } lpbk_st_e;
endpackage

// File: rtl/lpbk_ctrl.sv
module lpbk_ctrl
  import lpbk_pkg::*;
#(
  parameter int LEN_W  = 7,
  parameter int WORD_W = 32,
  parameter int CH_W   = 1,
  localparam int ADDR_W = LEN_W - 1,
  localparam int CNT_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_hw_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              bit_en_i,
  output logic              rd_en_o,
  output logic              word_load_o,
  output logic              bit_shift_o,
  output logic              word_wr_o,
  output logic              last_word_o,
  output logic              half_word_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CH_W-1:0]   ch_o,
  output logic              shifting_o,
  output logic              busy_o,
  output logic              done_o
);
  // index of the final word for a halfword count (count must be nonzero)
  function automatic logic [ADDR_W-1:0] last_index(input logic [LEN_W-1:0] n_hw);
    logic [LEN_W:0] n_words;
    n_words = ({1'b0, n_hw} + 1'b1) >> 1;
    return ADDR_W'(n_words - 1'b1);
  endfunction

  // bit counter value on the last strobe of a word
  function automatic logic [CNT_W-1:0] final_bit(input logic fold);
    return fold ? CNT_W'(WORD_W / 2 - 1) : CNT_W'(WORD_W - 1);
  endfunction

  lpbk_st_e          state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] last_q;
  logic              odd_q;
  logic [CH_W-1:0]   ch_q;
  logic [CNT_W-1:0]  cnt_q;

  assign last_word_o = (addr_q == last_q);
  assign half_word_o = last_word_o && odd_q;
  assign rd_en_o     = (state_q == ST_FETCH);
  assign word_load_o = (state_q == ST_LOAD);
  assign shifting_o  = (state_q == ST_SHIFT);
  assign bit_shift_o = shifting_o && bit_en_i;
  assign word_wr_o   = (state_q == ST_WRITE);
  assign done_o      = (state_q == ST_DONE);
  assign busy_o      = (state_q != ST_IDLE);
  assign addr_o      = addr_q;
  assign ch_o        = ch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      last_q  <= '0;
      odd_q   <= 1'b0;
      ch_q    <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            ch_q    <= chan_i;
            odd_q   <= len_hw_i[0];
            last_q  <= last_index(len_hw_i);
            addr_q  <= '0;
            state_q <= (len_hw_i == '0) ? ST_DONE : ST_FETCH;
          end
        end
        ST_FETCH: state_q <= ST_LOAD;
        ST_LOAD: begin
          cnt_q   <= '0;
          state_q <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (bit_en_i) begin
            if (cnt_q == final_bit(half_word_o)) begin
              state_q <= ST_WRITE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_WRITE: begin
          if (last_word_o) begin
            state_q <= ST_DONE;
          end else begin
            addr_q  <= addr_q + 1'b1;
            state_q <= ST_FETCH;
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lpbk_shift.sv
module lpbk_shift #(
  parameter int WORD_W = 32,
  localparam int HALF_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  input  logic              shift_i,
  input  logic              fold_i,
  output logic              ser_bit_o,
  output logic [WORD_W-1:0] word_o
);
  // after a half rotation the sent halfword sits in the low half
  function automatic logic [WORD_W-1:0] fold_half(input logic [WORD_W-1:0] w);
    return {{HALF_W{1'b0}}, w[HALF_W-1:0]};
  endfunction

  logic [WORD_W-1:0] sr_q;
  logic              loop_bit;

  assign ser_bit_o = sr_q[WORD_W-1];
  assign loop_bit  = ser_bit_o;  // serial output returned to the input
  assign word_o    = fold_i ? fold_half(sr_q) : sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= data_i;
    end else if (shift_i) begin
      sr_q <= {sr_q[WORD_W-2:0], loop_bit};
    end
  end
endmodule

// File: rtl/lpbk_word_engine.sv
module lpbk_word_engine #(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 7,
  parameter int NUM_CH = 2,
  localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int ADDR_W = LEN_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  len_hw_i,
  input  logic [CH_W-1:0]   chan_i,
  input  logic              bit_en_i,
  output logic              tx_rd_en_o,
  output logic [CH_W-1:0]   tx_rd_ch_o,
  output logic [ADDR_W-1:0] tx_rd_addr_o,
  input  logic [WORD_W-1:0] tx_rd_data_i,
  output logic              rx_wr_en_o,
  output logic [CH_W-1:0]   rx_wr_ch_o,
  output logic [ADDR_W-1:0] rx_wr_addr_o,
  output logic [WORD_W-1:0] rx_wr_data_o,
  output logic              ser_o,
  output logic              ser_en_o,
  output logic              busy_o,
  output logic              done_o
);
  // named internal events, also observed by the bound checker
  logic              word_load;
  logic              bit_shift;
  logic              word_wr;
  logic              last_word;
  logic              half_word;
  logic              shifting;
  logic              ser_bit;
  logic [ADDR_W-1:0] addr;
  logic [CH_W-1:0]   ch;

  lpbk_ctrl #(
    .LEN_W (LEN_W),
    .WORD_W(WORD_W),
    .CH_W  (CH_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .len_hw_i   (len_hw_i),
    .chan_i     (chan_i),
    .bit_en_i   (bit_en_i),
    .rd_en_o    (tx_rd_en_o),
    .word_load_o(word_load),
    .bit_shift_o(bit_shift),
    .word_wr_o  (word_wr),
    .last_word_o(last_word),
    .half_word_o(half_word),
    .addr_o     (addr),
    .ch_o       (ch),
    .shifting_o (shifting),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );

  lpbk_shift #(
    .WORD_W(WORD_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (word_load),
    .data_i   (tx_rd_data_i),
    .shift_i  (bit_shift),
    .fold_i   (half_word),
    .ser_bit_o(ser_bit),
    .word_o   (rx_wr_data_o)
  );

  assign tx_rd_ch_o   = ch;
  assign tx_rd_addr_o = addr;
  assign rx_wr_en_o   = word_wr;
  assign rx_wr_ch_o   = ch;
  assign rx_wr_addr_o = addr;
  assign ser_en_o     = shifting;
  assign ser_o        = shifting ? ser_bit : 1'b1;
endmodule

// File: rtl/lpbk_chk.sv
module lpbk_chk #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 6,
  parameter int CH_W   = 1,
  localparam int HALF_W = WORD_W / 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              ser_o,
  input logic              ser_en_o,
  input logic              tx_rd_en_o,
  input logic [ADDR_W-1:0] tx_rd_addr_o,
  input logic [CH_W-1:0]   tx_rd_ch_o,
  input logic              rx_wr_en_o,
  input logic [ADDR_W-1:0] rx_wr_addr_o,
  input logic [WORD_W-1:0] rx_wr_data_o,
  input logic              word_load,
  input logic              word_wr,
  input logic              last_word,
  input logic              half_word
);
  logic              pend_q;
  logic [ADDR_W-1:0] last_rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      last_rd_q <= '0;
    end else begin
      if (word_load) pend_q <= 1'b1;
      else if (word_wr) pend_q <= 1'b0;
      if (tx_rd_en_o) last_rd_q <= tx_rd_addr_o;
    end
  end

  p_wr_before_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |-> !pend_q);

  p_wr_has_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    word_wr |-> pend_q);

  p_wr_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_wr_en_o |-> (rx_wr_addr_o == last_rd_q));

  p_odd_fold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_en_o && half_word) |-> (rx_wr_data_o[WORD_W-1:HALF_W] == '0));

  p_chan_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(tx_rd_ch_o));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_wr_en_o && last_word) |=> done_o);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_o && start_i) |=> busy_o);

  p_ser_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_en_o |-> ser_o);
endmodule

bind lpbk_word_engine lpbk_chk #(
  .WORD_W(WORD_W),
  .ADDR_W(ADDR_W),
  .CH_W  (CH_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .ser_o       (ser_o),
  .ser_en_o    (ser_en_o),
  .tx_rd_en_o  (tx_rd_en_o),
  .tx_rd_addr_o(tx_rd_addr_o),
  .tx_rd_ch_o  (tx_rd_ch_o),
  .rx_wr_en_o  (rx_wr_en_o),
  .rx_wr_addr_o(rx_wr_addr_o),
  .rx_wr_data_o(rx_wr_data_o),
  .word_load   (word_load),
  .word_wr     (word_wr),
  .last_word   (last_word),
  .half_word   (half_word)
);

// File: tb/sim_lpbk_word_engine.sv
`timescale 1ns/1ps
module sim_lpbk_word_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [6:0]  len_hw_i = '0;
  logic [0:0]  chan_i = '0;
  logic        bit_en_i = 1'b0;
  logic        tx_rd_en_o;
  logic [0:0]  tx_rd_ch_o;
  logic [5:0]  tx_rd_addr_o;
  logic [31:0] tx_rd_data_i = '0;
  logic        rx_wr_en_o;
  logic [0:0]  rx_wr_ch_o;
  logic [5:0]  rx_wr_addr_o;
  logic [31:0] rx_wr_data_o;
  logic        ser_o, ser_en_o, busy_o, done_o;

  lpbk_word_engine u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_hw_i(len_hw_i),
    .chan_i(chan_i), .bit_en_i(bit_en_i), .tx_rd_en_o(tx_rd_en_o),
    .tx_rd_ch_o(tx_rd_ch_o), .tx_rd_addr_o(tx_rd_addr_o),
    .tx_rd_data_i(tx_rd_data_i), .rx_wr_en_o(rx_wr_en_o),
    .rx_wr_ch_o(rx_wr_ch_o), .rx_wr_addr_o(rx_wr_addr_o),
    .rx_wr_data_o(rx_wr_data_o), .ser_o(ser_o), .ser_en_o(ser_en_o),
    .busy_o(busy_o), .done_o(done_o)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int en_mode = 0;

  // monitor state
  int exp_ch, nw, odd_len;
  int n_rd, n_wr, n_bit, n_done;
  int m_rd_bad, m_wr_bad, m_order_bad, m_bit_bad, m_done_bad, m_idle_bad;
  logic        prev_wr;
  logic [31:0] last_wr_data;

  function automatic logic [31:0] tx_word(int ch, int a);
    logic [31:0] av;
    av = 32'(a);
    return (32'h9E3779B1 * (av + 1)) ^ (ch != 0 ? 32'h5A5A0F0F : 32'h0) ^ {av[7:0], 24'h0};
  endfunction

  // transmit buffer model: one-cycle registered read
  always @(posedge clk) begin
    if (tx_rd_en_o) tx_rd_data_i <= tx_word(int'(tx_rd_ch_o), int'(tx_rd_addr_o));
  end

  // bit-clock strobe pattern: every cycle, or every third cycle
  always @(posedge clk) begin
    #1;
    cyc++;
    bit_en_i = (en_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_rd_en_o) begin
        if (int'(tx_rd_addr_o) != n_rd || int'(tx_rd_ch_o) != exp_ch) m_rd_bad++;
        if (n_wr != n_rd) m_order_bad++;
        n_rd++;
      end
      if (rx_wr_en_o) begin
        logic [31:0] w, e;
        w = tx_word(exp_ch, n_wr);
        e = (odd_len != 0 && n_wr == nw - 1) ? {16'h0, w[31:16]} : w;
        if (int'(rx_wr_addr_o) != n_wr || int'(rx_wr_ch_o) != exp_ch || rx_wr_data_o != e)
          m_wr_bad++;
        last_wr_data = rx_wr_data_o;
        n_wr++;
      end
      if (ser_en_o && bit_en_i) begin
        logic [31:0] w;
        w = tx_word(exp_ch, n_bit / 32);
        if (ser_o != w[31 - (n_bit % 32)]) m_bit_bad++;
        n_bit++;
      end
      if (done_o) begin
        n_done++;
        if (nw > 0 && !prev_wr) m_done_bad++;
      end
      if (!ser_en_o && !ser_o) m_idle_bad++;
      prev_wr = rx_wr_en_o;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy_o && !done_o, "R1 busy/done low in reset", int'({busy_o, done_o}), 0);
    check(!tx_rd_en_o && !rx_wr_en_o, "R1 no buffer access in reset",
          int'({tx_rd_en_o, rx_wr_en_o}), 0);
    check(ser_o && !ser_en_o, "R1 R10 serial idle high", int'({ser_o, ser_en_o}), 2);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic run_xfer(input int ch, input int len, input int mode, input bit poke);
    int exp_bits;
    logic [31:0] lw;
    @(posedge clk); #2;
    exp_ch = ch; nw = (len + 1) / 2; odd_len = len % 2; en_mode = mode;
    n_rd = 0; n_wr = 0; n_bit = 0; n_done = 0; prev_wr = 1'b0;
    m_rd_bad = 0; m_wr_bad = 0; m_order_bad = 0; m_bit_bad = 0; m_done_bad = 0; m_idle_bad = 0;
    start_i = 1'b1; chan_i = 1'(ch); len_hw_i = 7'(len);
    @(posedge clk); #2 start_i = 1'b0;
    if (poke) begin
      repeat (40) @(posedge clk);
      #2 start_i = 1'b1; chan_i = 1'(1 - ch); len_hw_i = 7'd3;
      @(posedge clk); #2 start_i = 1'b0;
    end
    for (int i = 0; i < 30000; i++) begin
      @(negedge clk);
      if (done_o) break;
    end
    repeat (3) @(negedge clk);
    #1;
    exp_bits = 32 * nw - 16 * odd_len;
    check(n_rd == nw, "R2 read count", n_rd, nw);
    check(m_rd_bad == 0, "R2 R6 read address/channel", m_rd_bad, 0);
    check(n_wr == nw && m_wr_bad == 0, "R4 R6 receive writes", m_wr_bad, 0);
    check(m_order_bad == 0, "R4 write before next read", m_order_bad, 0);
    check(n_bit == exp_bits, "R3 strobe count", n_bit, exp_bits);
    check(m_bit_bad == 0, "R3 MSB-first serial bits", m_bit_bad, 0);
    check(n_done == 1 && m_done_bad == 0, "R7 single done after last write", n_done, 1);
    check(!busy_o, "R7 idle after done", int'(busy_o), 0);
    check(m_idle_bad == 0, "R10 ser_o high when not shifting", m_idle_bad, 0);
    if (odd_len != 0) begin
      lw = tx_word(ch, nw - 1);
      check(last_wr_data == {16'h0, lw[31:16]}, "R5 odd tail right-aligned",
            int'(last_wr_data), int'({16'h0, lw[31:16]}));
    end
    if (len == 0) check(n_rd == 0 && n_wr == 0 && n_done == 1, "R9 empty payload", n_done, 1);
    if (poke) check(n_rd == nw && n_done == 1, "R8 start while busy ignored", n_rd, nw);
  endtask

  initial begin
    t_reset();
    run_xfer(0, 8, 0, 1'b0);     // even, every-cycle strobe
    run_xfer(1, 7, 1, 1'b0);     // odd, sparse strobe, other channel
    run_xfer(0, 1, 1, 1'b0);     // single halfword
    run_xfer(1, 0, 0, 1'b0);     // empty
    run_xfer(0, 2, 1, 1'b0);     // single full word
    run_xfer(1, 127, 0, 1'b0);   // maximum length
    run_xfer(0, 10, 1, 1'b1);    // start request during transfer
    run_xfer(1, 126, 1, 1'b0);   // largest even length, sparse strobe
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule